// File: doc/BRIEF.md
# Even/Odd Bit-Line Group Select Decoder

This block drives the bit-line select vector of one memory subarray. In normal operation it decodes a binary column address into a single active select line, so one cell on the current word line is read or written. In test operation the address path is shut off, and two active-low group controls instead enable every even-indexed or every odd-indexed bit line together. A single write then reaches half the cells on a word line at once, and a single read presents them to a comparator side by side.

Each select output is the OR of its address-decode term and its parity-group term. The test input gates both terms, so only one of them can ever be live. The combined vector is registered once, so that it lines up with the array access cycle that follows.

Top module: `bitline_group_decoder`

## Requirements
- R1: While rst_n is low, and in the first cycle after it rises before any clock edge, sel_q is all zeros.
- R2: With test_en=0, sel_q after the next rising clock edge has exactly one bit set, at index col_addr.
- R3: With test_en=0, the values of even_grp_n and odd_grp_n have no effect on sel_q.
- R4: With test_en=1, col_addr has no effect on sel_q.
- R5: With test_en=1, even_grp_n=0 and odd_grp_n=1, sel_q has every bit with index bit 0 equal to 0 set and all other bits clear.
- R6: With test_en=1, even_grp_n=1 and odd_grp_n=0, sel_q has every bit with index bit 0 equal to 1 set and all other bits clear.
- R7: With test_en=1 and both group controls at 0, every bit of sel_q is set.
- R8: With test_en=1 and both group controls at 1, every bit of sel_q is clear.
- R9: sel_q reflects the inputs sampled at the most recent rising clock edge, and does not change between edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; select vector registered on rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| test_en | input | 1 | 1 selects parity-group mode, 0 selects address decode |
| col_addr | input | ADDR_W | Binary column address, used in normal mode |
| even_grp_n | input | 1 | Active-low enable for even-indexed bit lines in test mode |
| odd_grp_n | input | 1 | Active-low enable for odd-indexed bit lines in test mode |
| sel_q | output | NUM_LINES | Registered bit-line select vector |

## Verification
The bench sweeps every column address with the group controls toggled to every combination, because a design that leaked the group term into normal mode would show two or more active lines where one is expected. In test mode it walks the address through all values for each group setting, which exposes a decoder that is not shut off (an extra line at the address position under the "none" setting) and a swapped parity mapping (even and odd patterns exchanged). It also checks the output just after inputs change mid-cycle, which catches a select vector that slipped to a combinational path, and it applies reset mid-run to catch a vector that survives reset.

// File: rtl/bl_dec_pkg.sv
package bl_dec_pkg;

    typedef enum logic [1:0] {
        GM_NONE = 2'b00,
        GM_EVEN = 2'b01,
        GM_ODD  = 2'b10,
        GM_ALL  = 2'b11
    } grp_mode_e;

    // Active-low controls to a two-bit enable: bit 0 = even lines, bit 1 = odd lines
    function automatic grp_mode_e grp_mode(input logic even_n, input logic odd_n);
        return grp_mode_e'({~odd_n, ~even_n});
    endfunction

endpackage

// File: rtl/bl_onehot_dec.sv
module bl_onehot_dec #(
    parameter int NUM_LINES = 16,
    parameter int ADDR_W    = $clog2(NUM_LINES)
) (
    input  logic                 dec_en,
    input  logic [ADDR_W-1:0]    addr,
    output logic [NUM_LINES-1:0] lines
);

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
        localparam logic [ADDR_W-1:0] MATCH = ADDR_W'(i);
        assign lines[i] = dec_en && (addr == MATCH);
    end

    // R2: the address decode never raises more than one line
    always_comb begin
        if (!$isunknown(lines)) begin
            a_r2_dec_onehot0: assert ($onehot0(lines));
        end
    end

endmodule

// File: rtl/bl_parity_group.sv
module bl_parity_group
    import bl_dec_pkg::*;
#(
    parameter int NUM_LINES = 16
) (
    input  logic                 test_en,
    input  logic                 even_grp_n,
    input  logic                 odd_grp_n,
    output logic [NUM_LINES-1:0] lines
);

    grp_mode_e mode;

    always_comb begin
        mode = grp_mode(even_grp_n, odd_grp_n);
    end

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
        localparam int PARITY = i % 2;
        assign lines[i] = test_en && mode[PARITY];
    end

    // R3: the group term stays idle outside test mode
    always_comb begin
        if (test_en === 1'b0 && !$isunknown(lines)) begin
            a_r3_grp_idle_normal: assert (lines == '0);
        end
    end

endmodule

// File: rtl/bitline_group_decoder.sv
module bitline_group_decoder #(
    parameter int NUM_LINES = 16,
    parameter int ADDR_W    = $clog2(NUM_LINES)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 test_en,
    input  logic [ADDR_W-1:0]    col_addr,
    input  logic                 even_grp_n,
    input  logic                 odd_grp_n,
    output logic [NUM_LINES-1:0] sel_q
);

    localparam int HALF = NUM_LINES / 2;

    typedef struct packed {
        logic [NUM_LINES-1:0] sel;
    } state_t;

    state_t              st_d, st_q;
    logic [ADDR_W-1:0]   addr_gated;
    logic [NUM_LINES-1:0] dec_lines;
    logic [NUM_LINES-1:0] grp_lines;

    // Address inputs forced to zero in test mode
    always_comb begin
        addr_gated = test_en ? '0 : col_addr;
    end

    bl_onehot_dec #(
        .NUM_LINES (NUM_LINES),
        .ADDR_W    (ADDR_W)
    ) u_dec (
        .dec_en (~test_en),
        .addr   (addr_gated),
        .lines  (dec_lines)
    );

    bl_parity_group #(
        .NUM_LINES (NUM_LINES)
    ) u_grp (
        .test_en    (test_en),
        .even_grp_n (even_grp_n),
        .odd_grp_n  (odd_grp_n),
        .lines      (grp_lines)
    );

    always_comb begin
        st_d     = st_q;
        st_d.sel = dec_lines | grp_lines;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sel_q = st_q.sel;

    // R1: cleared while reset is held
    a_r1_reset_clear: assert property (@(posedge clk) !rst_n |-> sel_q == '0);

    // R2: normal mode yields a single line at the address
    a_r2_normal_single: assert property (@(posedge clk) disable iff (!rst_n)
        !test_en |=> ($countones(sel_q) == 1 && sel_q[$past(col_addr)]));

    // R5: even group in test mode gives half the lines, all at even indices
    a_r5_even_group: assert property (@(posedge clk) disable iff (!rst_n)
        (test_en && !even_grp_n && odd_grp_n) |=>
        ($countones(sel_q) == HALF && !sel_q[1] && sel_q[0]));

    // R6: odd group in test mode
    a_r6_odd_group: assert property (@(posedge clk) disable iff (!rst_n)
        (test_en && even_grp_n && !odd_grp_n) |=>
        ($countones(sel_q) == HALF && sel_q[1] && !sel_q[0]));

    // R7: both groups in test mode select everything
    a_r7_all_lines: assert property (@(posedge clk) disable iff (!rst_n)
        (test_en && !even_grp_n && !odd_grp_n) |=> (&sel_q));

    // R8: no group in test mode selects nothing, whatever the address
    a_r8_no_lines: assert property (@(posedge clk) disable iff (!rst_n)
        (test_en && even_grp_n && odd_grp_n) |=> (sel_q == '0));

    // R4: test-mode output does not follow the address
    a_r4_addr_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (test_en && $past(test_en) && $stable(even_grp_n) && $stable(odd_grp_n)
         && $past(rst_n)) |=> $stable(sel_q));

endmodule

// File: tb/sim_bitline_group_decoder.sv
`timescale 1ns/1ps
module sim_bitline_group_decoder;

    localparam int NL = 16;
    localparam int AW = $clog2(NL);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          test_en = 1'b0;
    logic [AW-1:0] col_addr = '0;
    logic          even_grp_n = 1'b1;
    logic          odd_grp_n = 1'b1;
    logic [NL-1:0] sel_q;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2 clk = ~clk;

    bitline_group_decoder #(.NUM_LINES(NL)) u0 (
        .clk(clk), .rst_n(rst_n), .test_en(test_en), .col_addr(col_addr),
        .even_grp_n(even_grp_n), .odd_grp_n(odd_grp_n), .sel_q(sel_q)
    );

    // Behavioural reference: what a select line must be for given inputs
    function automatic logic [NL-1:0] ref_sel(input logic t, input int a,
                                              input logic en_n, input logic on_n);
        logic [NL-1:0] v = '0;
        for (int i = 0; i < NL; i++) begin
            if (!t) v[i] = (i == a);
            else if (i % 2 == 0) v[i] = !en_n;
            else v[i] = !on_n;
        end
        return v;
    endfunction

    function automatic string req_of(input logic r, input logic t,
                                     input logic en_n, input logic on_n);
        if (!r) return "R1";
        if (!t) return "R2/R3";
        if (!en_n && on_n) return "R5/R4";
        if (en_n && !on_n) return "R6/R4";
        if (!en_n && !on_n) return "R7/R4";
        return "R8/R4";
    endfunction

    logic [NL-1:0] model_q;
    string         model_tag;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            model_q   <= '0;
            model_tag <= "R1";
        end else begin
            model_q   <= ref_sel(test_en, int'(col_addr), even_grp_n, odd_grp_n);
            model_tag <= req_of(rst_n, test_en, even_grp_n, odd_grp_n);
        end
    end

    task automatic check(input string tag, input logic [NL-1:0] exp);
        n_tests++;
        if (sel_q !== exp) begin
            n_fail++;
            $display("FAIL %s: sel_q=%h expected %h at %0t", tag, sel_q, exp, $time);
        end
    endtask

    // Compare against the model on every clock, away from the edge
    always @(negedge clk) begin
        if (!done) check(model_tag, model_q);
    end

    // Drive at the negative edge, then confirm R9: no change before the next edge
    task automatic drive(input logic t, input int a, input logic en_n, input logic on_n);
        @(negedge clk);
        #0.2;
        test_en    = t;
        col_addr   = AW'(a);
        even_grp_n = en_n;
        odd_grp_n  = on_n;
        #0.5;
        check("R9", model_q);
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: run did not finish, expected completion");
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        #1;
        check("R1", '0);
        repeat (3) @(posedge clk);
        #1;
        check("R1", '0);
        @(negedge clk);
        rst_n = 1'b1;
        #0.5;
        check("R1", '0);

        // R2/R3: every address with every group setting in normal mode
        for (int a = 0; a < NL; a++) begin
            for (int g = 0; g < 4; g++) begin
                drive(1'b0, a, g[0], g[1]);
            end
        end

        // R4..R8: every group setting against every address in test mode
        for (int g = 0; g < 4; g++) begin
            for (int a = 0; a < NL; a++) begin
                drive(1'b1, a, g[0], g[1]);
            end
        end

        // Explicit boundary points
        drive(1'b1, NL - 1, 1'b1, 1'b1);
        @(posedge clk); #1;
        check("R8", '0);
        drive(1'b1, 0, 1'b0, 1'b1);
        @(posedge clk); #1;
        check("R5", {(NL/2){2'b01}});
        drive(1'b1, 0, 1'b1, 1'b0);
        @(posedge clk); #1;
        check("R6", {(NL/2){2'b10}});
        drive(1'b1, 5, 1'b0, 1'b0);
        @(posedge clk); #1;
        check("R7", '1);
        drive(1'b0, NL - 1, 1'b0, 1'b0);
        @(posedge clk); #1;
        check("R2", NL'(1) << (NL - 1));

        // Mixed traffic with mode switches every few cycles
        for (int k = 0; k < 400; k++) begin
            drive(1'(($urandom % 3) == 0), int'($urandom % NL),
                  1'($urandom), 1'($urandom));
        end

        // R1: reset in the middle of a test-mode burst
        drive(1'b1, 3, 1'b0, 1'b0);
        @(negedge clk);
        rst_n = 1'b0;
        #0.5;
        check("R1", '0);
        @(posedge clk); #1;
        check("R1", '0);
        @(negedge clk);
        rst_n = 1'b1;
        drive(1'b0, 7, 1'b0, 1'b1);
        @(posedge clk); #1;
        check("R2", NL'(1) << 7);

        @(negedge clk);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule